// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch status of a single thread and recomputes it every cycle. Later pipeline stages send it back-pressure as block and unblock pulses. Commit and decode send it squash requests that carry a redirect address. The instruction cache side reports when a line request was issued, accepted or refused, when a retry slot is granted, and when a response returns. A fixed priority decides the next status from these events. The redirect address is loaded into a three-deep program counter window.

Cache responses are matched against the tag of the outstanding request. A response that arrives in the wrong state, or that carries a stale tag, is dropped and counted. A squash cancels the outstanding miss. If the thread holds the single retry slot, the squash also releases that slot and clears the cache-blocked indication. Trap and quiesce events park the thread until a wake event arrives.

Top module: `fetch_status_ctl`

## Requirements
- R1: Each of the four back-pressure sources (index 0 decode, 1 rename, 2 execute, 3 commit) owns a sticky stall flag. A block pulse sets the flag and an unblock pulse clears it. The flag takes effect in the same cycle as the pulse.
- R2: A commit squash has the highest priority. On the next cycle the status is Squashing, the PC equals the commit redirect, the next PC equals redirect+4 and the next-next PC equals redirect+8. This holds even when a decode squash or a stall arrives in the same cycle.
- R3: When there is no commit squash and commit reports that it is still squashing, the next status is Squashing.
- R4: A decode squash loads the decode redirect into the PC window and enters Squashing only when the current status is not Squashing. Otherwise it is ignored and the PC is unchanged.
- R5: When no higher rule applies, an active stall (any flag, or the context-switch input) moves the status to Blocked, unless the status is WaitResponse.
- R6: When no higher rule applies and the status is Blocked or Squashing, the status returns to Running.
- R7: A cache response is accepted only in WaitResponse, with its tag equal to the outstanding request tag, and with no squash in the same cycle. Any other response is dropped and increments the drop counter.
- R8: An accepted response sets the line-valid output. The status becomes Blocked if a stall is active and AccessComplete if none is. Issuing a new request clears line-valid.
- R9: A commit squash or an effective decode squash cancels the outstanding miss. It also releases a held retry slot, so the cache-blocked output is 0 on the next cycle.
- R10: A request issued from Running or AccessComplete goes to WaitResponse when the cache accepts it. When the cache refuses it, the status goes to WaitRetry and cache-blocked is set. A retry grant that is accepted moves WaitRetry to WaitResponse and clears cache-blocked.
- R11: The status-changed output is 1 exactly in the cycles where the status value differs from its value one cycle before. Status codes: Running 0, Idle 1, Squashing 2, Blocked 3, WaitResponse 4, WaitRetry 5, AccessComplete 6, TrapPending 7, QuiescePending 8.
- R12: Reset gives status Idle, PC equal to the reset address, cache-blocked 0, line-valid 0, drop count 0 and status-changed 0. A start pulse moves Idle to Running. Trap and quiesce move Running to TrapPending and QuiescePending respectively. Wake returns both of those states to Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Leave Idle |
| blockIn | input | NUM_STAGES | Block pulses, one per stage |
| unblockIn | input | NUM_STAGES | Unblock pulses, one per stage |
| ctxSwitchIn | input | 1 | Global context-switch stall level |
| cmtSquashIn | input | 1 | Squash from commit |
| cmtRedirectIn | input | ADDR_W | Commit redirect address |
| cmtStillSquashingIn | input | 1 | Commit still squashing |
| decSquashIn | input | 1 | Squash from decode |
| decRedirectIn | input | ADDR_W | Decode redirect address |
| reqFireIn | input | 1 | Line request issued |
| reqAckIn | input | 1 | Cache accepted the issued request |
| reqTagIn | input | TAG_W | Tag of the issued request |
| respValidIn | input | 1 | Cache response present |
| respTagIn | input | TAG_W | Tag of the response |
| retryGrantIn | input | 1 | Retry slot resent |
| retryAckIn | input | 1 | Resent request accepted |
| trapIn | input | 1 | Trap event |
| quiesceIn | input | 1 | Quiesce event |
| wakeIn | input | 1 | Wake from trap or quiesce |
| statusOut | output | 4 | Status code |
| statusChangedOut | output | 1 | Status changed this cycle |
| pcOut | output | ADDR_W | Current PC |
| nextPcOut | output | ADDR_W | Next PC |
| nextNextPcOut | output | ADDR_W | Next-next PC |
| cacheBlockedOut | output | 1 | Retry slot held |
| lineValidOut | output | 1 | Line buffer valid |
| dropCountOut | output | DROP_W | Dropped response count |

## Verification
The assertions assume well-formed back-pressure on every stage. Block and unblock never coincide, and an unblock only arrives while that stage's flag is set. The stimulus table keeps to this: every unblock in it follows a matching block and is issued alone. The table also respects the protocol assumptions of the retry path. A retry grant appears only while the slot is held, and responses arrive only after a request was issued or as deliberate stale tags.

// File: rtl/fetch_status_pkg.sv
package fetch_status_pkg;
  typedef enum logic [3:0] {
    ST_RUNNING    = 4'd0,
    ST_IDLE       = 4'd1,
    ST_SQUASHING  = 4'd2,
    ST_BLOCKED    = 4'd3,
    ST_WAIT_RESP  = 4'd4,
    ST_WAIT_RETRY = 4'd5,
    ST_ACC_DONE   = 4'd6,
    ST_TRAP       = 4'd7,
    ST_QUIESCE    = 4'd8
  } fetchStatus_e;

  typedef struct packed {
    logic loadPc;
    logic useDec;
    logic cancelMiss;
    logic captureTag;
    logic setRetry;
    logic clrRetry;
    logic lineSet;
    logic lineClr;
    logic dropResp;
  } fetchStrobe_t;
endpackage

// File: rtl/fetch_stall_track.sv
module fetch_stall_track #(
  parameter int NUM_STAGES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_STAGES-1:0] blockIn,
  input  logic [NUM_STAGES-1:0] unblockIn,
  input  logic                  ctxSwitchIn,
  output logic                  stallAny
);
  logic [NUM_STAGES-1:0] flagsQ;
  logic [NUM_STAGES-1:0] flagsNext;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    assign flagsNext[i] = (flagsQ[i] | blockIn[i]) & ~unblockIn[i];

    always_ff @(posedge clk) begin
      if (!rstN) flagsQ[i] <= 1'b0;
      else       flagsQ[i] <= flagsNext[i];
    end

    // R1
    blk_unblk_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(blockIn[i] && unblockIn[i]));
    // R1
    unblk_when_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      unblockIn[i] |-> flagsQ[i]);
    // R1
    blk_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      blockIn[i] |=> flagsQ[i]);
  end

  assign stallAny = (|flagsNext) | ctxSwitchIn;
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fetch_status_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         stallAny,
  input  logic         cmtSquashIn,
  input  logic         cmtStillSquashingIn,
  input  logic         decSquashIn,
  input  logic         reqFireIn,
  input  logic         reqAckIn,
  input  logic         respValidIn,
  input  logic         tagHit,
  input  logic         retryHeld,
  input  logic         retryGrantIn,
  input  logic         retryAckIn,
  input  logic         trapIn,
  input  logic         quiesceIn,
  input  logic         wakeIn,
  output fetchStatus_e status,
  output logic         statusChanged,
  output fetchStrobe_t strobe
);
  fetchStatus_e nxt;
  logic         accepted;

  always_comb begin
    nxt      = status;
    strobe   = '0;
    accepted = 1'b0;
    if (cmtSquashIn) begin
      nxt = ST_SQUASHING;
      strobe.loadPc = 1'b1;
      strobe.cancelMiss = 1'b1;
    end else if (cmtStillSquashingIn) begin
      nxt = ST_SQUASHING;
    end else if (decSquashIn && status != ST_SQUASHING) begin
      nxt = ST_SQUASHING;
      strobe.loadPc = 1'b1;
      strobe.useDec = 1'b1;
      strobe.cancelMiss = 1'b1;
    end else if (stallAny && status != ST_WAIT_RESP) begin
      nxt = ST_BLOCKED;
    end else if (status == ST_BLOCKED || status == ST_SQUASHING) begin
      nxt = ST_RUNNING;
    end else if (respValidIn && status == ST_WAIT_RESP && tagHit) begin
      accepted = 1'b1;
      strobe.lineSet = 1'b1;
      nxt = stallAny ? ST_BLOCKED : ST_ACC_DONE;
    end else begin
      case (status)
        ST_IDLE: if (startIn) nxt = ST_RUNNING;
        ST_RUNNING, ST_ACC_DONE: begin
          if (trapIn)          nxt = ST_TRAP;
          else if (quiesceIn)  nxt = ST_QUIESCE;
          else if (reqFireIn && !retryHeld) begin
            strobe.captureTag = 1'b1;
            strobe.lineClr = 1'b1;
            if (reqAckIn) nxt = ST_WAIT_RESP;
            else begin
              nxt = ST_WAIT_RETRY;
              strobe.setRetry = 1'b1;
            end
          end
        end
        ST_WAIT_RETRY: if (retryGrantIn && retryAckIn) begin
          nxt = ST_WAIT_RESP;
          strobe.clrRetry = 1'b1;
        end
        ST_TRAP, ST_QUIESCE: if (wakeIn) nxt = ST_RUNNING;
        default: nxt = status;
      endcase
    end
    strobe.dropResp = respValidIn && !accepted;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status        <= ST_IDLE;
      statusChanged <= 1'b0;
    end else begin
      status        <= nxt;
      statusChanged <= (nxt != status);
    end
  end

  // R2
  cmt_squash_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmtSquashIn |=> status == ST_SQUASHING);
  // R3
  still_squash_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmtStillSquashingIn |=> status == ST_SQUASHING);
  // R5
  wait_resp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_WAIT_RESP && !cmtSquashIn && !cmtStillSquashingIn &&
     !decSquashIn && !respValidIn) |=> status == ST_WAIT_RESP);
  // R11
  chg_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusChanged == (status != $past(status)));
endmodule

// File: rtl/fetch_status_dp.sv
module fetch_status_dp
  import fetch_status_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              TAG_W      = 4,
  parameter int              DROP_W     = 8,
  parameter int              INST_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobe_t      strobe,
  input  logic [ADDR_W-1:0] cmtRedirectIn,
  input  logic [ADDR_W-1:0] decRedirectIn,
  input  logic [TAG_W-1:0]  reqTagIn,
  input  logic [TAG_W-1:0]  respTagIn,
  output logic              tagHit,
  output logic              retryHeld,
  output logic              lineValid,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] nextNextPc,
  output logic [DROP_W-1:0] dropCount
);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INST_BYTES);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INST_BYTES);

  logic [TAG_W-1:0]  tagQ;
  logic              tagValid;
  logic [ADDR_W-1:0] redirect;

  assign redirect = strobe.useDec ? decRedirectIn : cmtRedirectIn;
  assign tagHit   = tagValid && (respTagIn == tagQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc         <= RESET_PC;
      nextPc     <= RESET_PC + STEP1;
      nextNextPc <= RESET_PC + STEP2;
      tagQ       <= '0;
      tagValid   <= 1'b0;
      retryHeld  <= 1'b0;
      lineValid  <= 1'b0;
      dropCount  <= '0;
    end else begin
      if (strobe.loadPc) begin
        pc         <= redirect;
        nextPc     <= redirect + STEP1;
        nextNextPc <= redirect + STEP2;
      end
      if (strobe.captureTag) begin
        tagQ     <= reqTagIn;
        tagValid <= 1'b1;
      end else if (strobe.cancelMiss || strobe.lineSet) begin
        tagValid <= 1'b0;
      end
      if (strobe.setRetry)                         retryHeld <= 1'b1;
      else if (strobe.clrRetry || strobe.cancelMiss) retryHeld <= 1'b0;
      if (strobe.lineSet)      lineValid <= 1'b1;
      else if (strobe.lineClr) lineValid <= 1'b0;
      if (strobe.dropResp) dropCount <= dropCount + 1'b1;
    end
  end

  // R2
  redirect_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadPc && !strobe.useDec) |=>
      (pc == $past(cmtRedirectIn) && nextPc == pc + STEP1 && nextNextPc == pc + STEP2));
  // R7
  drop_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dropResp |=> dropCount == DROP_W'($past(dropCount) + 1'b1));
  // R9
  retry_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cancelMiss |=> !retryHeld);
endmodule

// File: rtl/fetch_status_ctl.sv
module fetch_status_ctl
  import fetch_status_pkg::*;
#(
  parameter int              NUM_STAGES = 4,
  parameter int              ADDR_W     = 32,
  parameter int              TAG_W      = 4,
  parameter int              DROP_W     = 8,
  parameter int              INST_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startIn,
  input  logic [NUM_STAGES-1:0] blockIn,
  input  logic [NUM_STAGES-1:0] unblockIn,
  input  logic                  ctxSwitchIn,
  input  logic                  cmtSquashIn,
  input  logic [ADDR_W-1:0]     cmtRedirectIn,
  input  logic                  cmtStillSquashingIn,
  input  logic                  decSquashIn,
  input  logic [ADDR_W-1:0]     decRedirectIn,
  input  logic                  reqFireIn,
  input  logic                  reqAckIn,
  input  logic [TAG_W-1:0]      reqTagIn,
  input  logic                  respValidIn,
  input  logic [TAG_W-1:0]      respTagIn,
  input  logic                  retryGrantIn,
  input  logic                  retryAckIn,
  input  logic                  trapIn,
  input  logic                  quiesceIn,
  input  logic                  wakeIn,
  output logic [3:0]            statusOut,
  output logic                  statusChangedOut,
  output logic [ADDR_W-1:0]     pcOut,
  output logic [ADDR_W-1:0]     nextPcOut,
  output logic [ADDR_W-1:0]     nextNextPcOut,
  output logic                  cacheBlockedOut,
  output logic                  lineValidOut,
  output logic [DROP_W-1:0]     dropCountOut
);
  logic         stallAny;
  logic         tagHit;
  logic         retryHeld;
  fetchStatus_e status;
  fetchStrobe_t strobe;

  fetch_stall_track #(.NUM_STAGES(NUM_STAGES)) u_stall (
    .clk(clk), .rstN(rstN), .blockIn(blockIn), .unblockIn(unblockIn),
    .ctxSwitchIn(ctxSwitchIn), .stallAny(stallAny));

  fetch_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .stallAny(stallAny),
    .cmtSquashIn(cmtSquashIn), .cmtStillSquashingIn(cmtStillSquashingIn),
    .decSquashIn(decSquashIn), .reqFireIn(reqFireIn), .reqAckIn(reqAckIn),
    .respValidIn(respValidIn), .tagHit(tagHit), .retryHeld(retryHeld),
    .retryGrantIn(retryGrantIn), .retryAckIn(retryAckIn), .trapIn(trapIn),
    .quiesceIn(quiesceIn), .wakeIn(wakeIn), .status(status),
    .statusChanged(statusChangedOut), .strobe(strobe));

  fetch_status_dp #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .DROP_W(DROP_W),
    .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmtRedirectIn(cmtRedirectIn),
    .decRedirectIn(decRedirectIn), .reqTagIn(reqTagIn), .respTagIn(respTagIn),
    .tagHit(tagHit), .retryHeld(retryHeld), .lineValid(lineValidOut),
    .pc(pcOut), .nextPc(nextPcOut), .nextNextPc(nextNextPcOut),
    .dropCount(dropCountOut));

  assign statusOut       = status;
  assign cacheBlockedOut = retryHeld;
endmodule

// File: tb/fetch_status_ctl_tb.sv
module fetch_status_ctl_tb;
  typedef struct packed {
    logic        start;
    logic [3:0]  blk;
    logic [3:0]  unblk;
    logic        ctx;
    logic        cSq;
    logic        still;
    logic        dSq;
    logic [31:0] redir;
    logic        rF;
    logic        rAck;
    logic [3:0]  rTag;
    logic        respV;
    logic [3:0]  respTag;
    logic        rtG;
    logic        rtAck;
    logic        trap;
    logic        qui;
    logic        wake;
    logic [3:0]  eSt;
    logic [31:0] ePc;
    logic        eCb;
    logic        eLine;
  } vec_t;

  localparam int NV = 33;
  // fields: start blk unblk ctx cSq still dSq redir rF rAck rTag respV respTag rtG rtAck trap qui wake | eSt ePc eCb eLine
  localparam vec_t VEC [NV] = '{
    '{1,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd0,32'h1000,0,0}, // R12 start
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   1,1,4'h3,0,4'h0,0,0,0,0,0, 4'd4,32'h1000,0,0}, // R10 accepted
    '{0,4'h1,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd4,32'h1000,0,0}, // R5 wait-resp exempt
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,1,4'h3,0,0,0,0,0, 4'd3,32'h1000,0,1}, // R8 stalled accept
    '{0,4'h0,4'h1,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd0,32'h1000,0,1}, // R6
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   1,1,4'h5,0,4'h0,0,0,0,0,0, 4'd4,32'h1000,0,0}, // R8 clear line
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,1,4'h6,0,0,0,0,0, 4'd4,32'h1000,0,0}, // R7 stale tag
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,1,4'h5,0,0,0,0,0, 4'd6,32'h1000,0,1}, // R8 complete
    '{0,4'h2,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd3,32'h1000,0,1}, // R5
    '{0,4'h4,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd3,32'h1000,0,1}, // R1
    '{0,4'h0,4'h2,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd3,32'h1000,0,1}, // R1 execute still set
    '{0,4'h0,4'h4,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd0,32'h1000,0,1}, // R1 all clear
    '{0,4'h0,4'h0,0,1,0,0,32'h2000,0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd2,32'h2000,0,1}, // R2
    '{0,4'h0,4'h0,0,0,1,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd2,32'h2000,0,1}, // R3
    '{0,4'h0,4'h0,0,0,0,1,32'h3000,0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd0,32'h2000,0,1}, // R4 ignored
    '{0,4'h0,4'h0,0,0,0,1,32'h3000,0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd2,32'h3000,0,1}, // R4 taken
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd0,32'h3000,0,1}, // R6
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   1,0,4'h7,0,4'h0,0,0,0,0,0, 4'd5,32'h3000,1,0}, // R10 refused
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,1,1,0,0,0, 4'd4,32'h3000,0,0}, // R10 retry
    '{0,4'h0,4'h0,0,1,0,0,32'h4000,0,0,4'h0,1,4'h7,0,0,0,0,0, 4'd2,32'h4000,0,0}, // R7 squash drops
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd0,32'h4000,0,0}, // R6
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   1,0,4'h2,0,4'h0,0,0,0,0,0, 4'd5,32'h4000,1,0}, // R10
    '{0,4'h0,4'h0,0,0,0,1,32'h5000,0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd2,32'h5000,0,0}, // R9 release
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd0,32'h5000,0,0}, // R6
    '{0,4'h0,4'h0,1,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd3,32'h5000,0,0}, // R5 ctx
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd0,32'h5000,0,0}, // R6
    '{0,4'h8,4'h0,0,1,0,0,32'h6000,0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd2,32'h6000,0,0}, // R2 beats stall
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd3,32'h6000,0,0}, // R1 commit flag
    '{0,4'h0,4'h8,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,0, 4'd0,32'h6000,0,0}, // R6
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,1,0,0, 4'd7,32'h6000,0,0}, // R12 trap
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,1, 4'd0,32'h6000,0,0}, // R12 wake
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,1,0, 4'd8,32'h6000,0,0}, // R12 quiesce
    '{0,4'h0,4'h0,0,0,0,0,32'h0,   0,0,4'h0,0,4'h0,0,0,0,0,1, 4'd0,32'h6000,0,0}  // R12 wake
  };

  logic clk = 0, rstN = 0;
  logic startIn, ctxSwitchIn, cmtSquashIn, cmtStillSquashingIn, decSquashIn;
  logic [3:0] blockIn, unblockIn, reqTagIn, respTagIn, statusOut;
  logic [31:0] cmtRedirectIn, decRedirectIn, pcOut, nextPcOut, nextNextPcOut;
  logic reqFireIn, reqAckIn, respValidIn, retryGrantIn, retryAckIn;
  logic trapIn, quiesceIn, wakeIn, statusChangedOut, cacheBlockedOut, lineValidOut;
  logic [7:0] dropCountOut;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fetch_status_ctl u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    startIn = 0; blockIn = 0; unblockIn = 0; ctxSwitchIn = 0; cmtSquashIn = 0;
    cmtStillSquashingIn = 0; decSquashIn = 0; cmtRedirectIn = 0; decRedirectIn = 0;
    reqFireIn = 0; reqAckIn = 0; reqTagIn = 0; respValidIn = 0; respTagIn = 0;
    retryGrantIn = 0; retryAckIn = 0; trapIn = 0; quiesceIn = 0; wakeIn = 0;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] prevSt;
    idle();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 status", 32'(statusOut), 32'd1);
    chk("R12 pc", pcOut, 32'h1000);
    chk("R12 cacheBlocked", 32'(cacheBlockedOut), 0);
    chk("R12 lineValid", 32'(lineValidOut), 0);
    chk("R12 drop", 32'(dropCountOut), 0);
    rstN = 1;
    @(negedge clk);
    chk("R11 no change", 32'(statusChangedOut), 0);
    prevSt = 4'd1;
    for (int i = 0; i < NV; i++) begin
      startIn = VEC[i].start; blockIn = VEC[i].blk; unblockIn = VEC[i].unblk;
      ctxSwitchIn = VEC[i].ctx; cmtSquashIn = VEC[i].cSq;
      cmtStillSquashingIn = VEC[i].still; decSquashIn = VEC[i].dSq;
      cmtRedirectIn = VEC[i].redir; decRedirectIn = VEC[i].redir;
      reqFireIn = VEC[i].rF; reqAckIn = VEC[i].rAck; reqTagIn = VEC[i].rTag;
      respValidIn = VEC[i].respV; respTagIn = VEC[i].respTag;
      retryGrantIn = VEC[i].rtG; retryAckIn = VEC[i].rtAck;
      trapIn = VEC[i].trap; quiesceIn = VEC[i].qui; wakeIn = VEC[i].wake;
      @(negedge clk);
      idle();
      chk($sformatf("R5/R6 status v%0d", i), 32'(statusOut), 32'(VEC[i].eSt));
      chk($sformatf("R2/R4 pc v%0d", i), pcOut, VEC[i].ePc);
      chk($sformatf("R10 cacheBlocked v%0d", i), 32'(cacheBlockedOut), 32'(VEC[i].eCb));
      chk($sformatf("R8 lineValid v%0d", i), 32'(lineValidOut), 32'(VEC[i].eLine));
      chk($sformatf("R11 changed v%0d", i), 32'(statusChangedOut),
          32'(VEC[i].eSt != prevSt));
      prevSt = VEC[i].eSt;
    end
    // R2 PC window
    chk("R2 nextPc", nextPcOut, 32'h6004);
    chk("R2 nextNextPc", nextNextPcOut, 32'h6008);
    // R7 two responses were dropped
    chk("R7 drop count", 32'(dropCountOut), 32'd2);
    // R2 commit beats decode in the same cycle
    cmtSquashIn = 1; cmtRedirectIn = 32'h7000;
    decSquashIn = 1; decRedirectIn = 32'h8000;
    @(negedge clk);
    idle();
    chk("R2 priority pc", pcOut, 32'h7000);
    chk("R2 priority status", 32'(statusOut), 32'd2);
    // R12 reset mid-run
    rstN = 0;
    @(negedge clk);
    chk("R12 re-reset status", 32'(statusOut), 32'd1);
    chk("R12 re-reset pc", pcOut, 32'h1000);
    chk("R12 re-reset drop", 32'(dropCountOut), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule